// File: doc/BRIEF.md
# Secure Scan Chain Controller

This block wraps the cipher state register of a cryptographic datapath in a scan chain that cannot be used to pull key material out of the chip. The register is built from resettable scan cells. The cells shift serially in test mode and capture the next state from the datapath in functional mode. Three guards are added around the cells. A mode guard watches the test-mode pin and wipes every cell on the clock edge after any change of that pin. Key loading is turned into a load of zeros while test mode is active. Shifting is refused in functional mode, whatever the scan enable pin says.

The serial pins are single-bit, as in a boundary-scan style test access path. Data leaves least significant bit first, one bit per clock. The scan output is held at zero whenever it could expose functional contents. There is no flow control on any pin: each clock edge performs exactly one cell operation. The cell operations, from highest to lowest priority, are clear, shift, key load (or zero load) and capture.

Top module: `secure_scan_ctrl`

## Requirements
- R1: While the asynchronous active-low reset is asserted, `state_q` is all zeros and `scan_out` is 0.
- R2: On the first clock edge after `test_mode` differs from its value at the previous edge, every cell becomes 0. This clear takes priority over shift, key load and capture in that cycle.
- R3: In test mode, `key_load` with `scan_enable` low loads all zeros. `key_data` never reaches `state_q` while `test_mode` is 1.
- R4: In functional mode (`test_mode` = 0), `scan_enable` has no effect. Without `key_load`, `state_q` takes `func_next` on every clock edge.
- R5: In test mode with `scan_enable` = 1, each edge performs `state_q <= {scan_in, state_q[W-1:1]}`, and `key_load` is ignored. `scan_out` shows `state_q[0]`, so a word shifted in LSB first reads back unchanged after W clocks.
- R6: In test mode with `scan_enable` = 0 and `key_load` = 0, `state_q` takes `func_next` (capture cycle).
- R7: In functional mode, `key_load` = 1 loads `key_data` into `state_q` on the next edge.
- R8: `scan_out` is 0 whenever `test_mode` is 0, and also during the cycle in which a mode change is pending.
- R9: Reset does not itself cause a clear. The first `test_mode` level seen after reset becomes the reference, so shifting can start on the first edge after reset even with `test_mode` held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | 1 = test mode, 0 = functional mode |
| scan_enable | input | 1 | Shift request, honoured only in test mode |
| scan_in | input | 1 | Serial scan data in, enters at the MSB |
| scan_out | output | 1 | Serial scan data out, LSB first, gated to 0 when unsafe |
| key_load | input | 1 | Request to load the cipher key into the state |
| key_data | input | W | Cipher key word |
| func_next | input | W | Next state from the cipher datapath |
| state_q | output | W | Current state register contents |

## Verification
The hardest case to reach from the ports is a mode change that arrives together with competing requests. In that cycle the clear must win over a pending key load, an asserted shift and a fresh capture value, and the output must already be silent. The bench first loads a known key in functional mode. It then flips `test_mode` while `key_load`, `scan_enable` and `scan_in` are all active, and flips back in the same way carrying a new key. It also toggles the mode on two consecutive cycles, so that back-to-back clears occur. A full sweep of all 256 shift patterns on an 8-bit chain checks the serial order, and each bit shifted out is compared against the previous pattern.

// File: rtl/secscan_pkg.sv
package secscan_pkg;
  typedef enum logic [2:0] {
    OP_CLEAR   = 3'd0,
    OP_SHIFT   = 3'd1,
    OP_ZERO    = 3'd2,
    OP_KEY     = 3'd3,
    OP_CAPTURE = 3'd4
  } cell_op_e;
endpackage

// File: rtl/secscan_mode_guard.sv
module secscan_mode_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  output logic clr_pulse
);
  logic prev_mode_q;
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mode_q <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      prev_mode_q <= test_mode;
      armed_q     <= 1'b1;
    end
  end

  assign clr_pulse = armed_q && (prev_mode_q != test_mode);

  // R2: a level change seen across two armed edges must raise the clear
  assert_clear_on_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(armed_q) && (test_mode != $past(test_mode))) |-> clr_pulse);

  // R9: the edge right after reset never produces a clear
  assert_no_clear_from_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(!clr_pulse));
endmodule

// File: rtl/secscan_cell.sv
module secscan_cell
  import secscan_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cell_op_e op,
  input  logic     d_shift,
  input  logic     d_func,
  input  logic     d_key,
  output logic     q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      case (op)
        OP_CLEAR:   q <= 1'b0;
        OP_SHIFT:   q <= d_shift;
        OP_ZERO:    q <= 1'b0;
        OP_KEY:     q <= d_key;
        OP_CAPTURE: q <= d_func;
        default:    q <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/secscan_chain.sv
module secscan_chain
  import secscan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cell_op_e     op,
  input  logic         scan_in,
  input  logic [W-1:0] func_next,
  input  logic [W-1:0] key_data,
  output logic [W-1:0] state
);
  localparam int MSB = W - 1;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic shift_src;
    if (i == MSB) begin : g_head
      assign shift_src = scan_in;
    end else begin : g_link
      assign shift_src = state[i+1];
    end
    secscan_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .d_shift(shift_src),
      .d_func (func_next[i]),
      .d_key  (key_data[i]),
      .q      (state[i])
    );
  end
endmodule

// File: rtl/secure_scan_ctrl.sv
module secure_scan_ctrl
  import secscan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         scan_enable,
  input  logic         scan_in,
  output logic         scan_out,
  input  logic         key_load,
  input  logic [W-1:0] key_data,
  input  logic [W-1:0] func_next,
  output logic [W-1:0] state_q
);
  localparam int MSB = W - 1;

  logic     clr_pulse;
  logic     shift_ok;
  cell_op_e op;

  secscan_mode_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_mode(test_mode),
    .clr_pulse(clr_pulse)
  );

  assign shift_ok = scan_enable && test_mode;

  always_comb begin
    if (clr_pulse)     op = OP_CLEAR;
    else if (shift_ok) op = OP_SHIFT;
    else if (key_load) op = test_mode ? OP_ZERO : OP_KEY;
    else               op = OP_CAPTURE;
  end

  secscan_chain #(.W(W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .scan_in  (scan_in),
    .func_next(func_next),
    .key_data (key_data),
    .state    (state_q)
  );

  assign scan_out = (test_mode && !clr_pulse) ? state_q[0] : 1'b0;

  // R2: a pending clear empties every cell at the next edge
  assert_clear_wipes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (state_q == '0));

  // R3: key request in test mode without shift leaves zeros
  assert_key_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && key_load && !scan_enable && !clr_pulse) |=> (state_q == '0));

  // R4: functional mode captures regardless of scan_enable
  assert_func_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !key_load && !clr_pulse) |=> (state_q == $past(func_next)));

  // R5: shift moves serial input into the MSB and the rest down one place
  assert_shift_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && scan_enable && !clr_pulse) |=>
      (state_q[MSB] == $past(scan_in)) && (state_q[MSB-1:0] == $past(state_q[MSB:1])));

  // R7: functional key load takes the key word
  assert_func_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && key_load && !clr_pulse) |=> (state_q == $past(key_data)));
endmodule

// File: tb/sim_secure_scan_ctrl.sv
`timescale 1ns/1ps
module sim_secure_scan_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         test_mode, scan_enable, scan_in, key_load;
  logic [W-1:0] key_data, func_next;
  logic         scan_out;
  logic [W-1:0] state_q;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] prev_pat;

  always #10 clk = ~clk;

  secure_scan_ctrl #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_enable(scan_enable),
    .scan_in(scan_in), .scan_out(scan_out), .key_load(key_load),
    .key_data(key_data), .func_next(func_next), .state_q(state_q)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; test_mode = 1'b0; scan_enable = 1'b0; scan_in = 1'b0;
    key_load = 1'b0; key_data = '0; func_next = 8'hFF;
    tick(); tick();
    chk("R1 state in reset", state_q, '0);
    chk("R1 scan_out in reset", {7'd0, scan_out}, '0);
    rst_n = 1'b1;

    // R4/R8: functional capture sweep, scan_enable toggling has no effect
    for (int v = 0; v < 256; v++) begin
      func_next = v[W-1:0]; scan_enable = v[0]; scan_in = v[1];
      tick();
      chk("R4 functional capture", state_q, v[W-1:0]);
      #1 chk("R8 scan_out silent in functional", {7'd0, scan_out}, '0);
    end
    scan_enable = 1'b0;

    // R7: functional key load
    for (int k = 0; k < 4; k++) begin
      key_data = 8'h5A ^ W'(k * 37); func_next = ~key_data; key_load = 1'b1;
      tick();
      chk("R7 functional key load", state_q, 8'h5A ^ W'(k * 37));
    end

    // R2: switch to test mode while key, shift and capture all compete
    key_data = 8'hC9; tick();
    test_mode = 1'b1; key_load = 1'b1; scan_enable = 1'b1; scan_in = 1'b1; func_next = 8'hFF;
    #1 chk("R8 scan_out silent while clear pending", {7'd0, scan_out}, '0);
    tick();
    chk("R2 clear on functional->test", state_q, '0);
    key_load = 1'b0;

    // R5: exhaustive shift sweep, each shift also reads back the prior pattern
    prev_pat = '0;
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < W; i++) begin
        scan_in = p[i]; scan_enable = 1'b1;
        #1 chk("R5 serial out LSB first", {7'd0, scan_out}, {7'd0, prev_pat[i]});
        tick();
      end
      chk("R5 shifted word", state_q, p[W-1:0]);
      prev_pat = p[W-1:0];
    end

    // R5: key_load ignored while shifting
    key_load = 1'b1; key_data = 8'hA5; scan_in = 1'b0;
    tick();
    chk("R5 key ignored during shift", state_q, 8'h7F);
    // R3: key load in test mode without shift yields zeros
    scan_enable = 1'b0;
    tick();
    chk("R3 key blocked in test mode", state_q, '0);
    key_data = 8'hFF; func_next = 8'h00;
    tick();
    chk("R3 key never reaches state", state_q, '0);
    key_load = 1'b0;

    // R6: capture cycle in test mode
    func_next = 8'h3C;
    tick();
    chk("R6 test-mode capture", state_q, 8'h3C);

    // R2: back to functional with a key pending; clear wins, then key loads
    test_mode = 1'b0; key_load = 1'b1; key_data = 8'h5A; func_next = 8'hC3;
    #1 chk("R8 scan_out silent on test->functional", {7'd0, scan_out}, '0);
    tick();
    chk("R2 clear on test->functional", state_q, '0);
    tick();
    chk("R7 key after clear", state_q, 8'h5A);
    key_load = 1'b0;

    // R2: toggle on consecutive cycles
    func_next = 8'h11;
    test_mode = 1'b1; tick();
    chk("R2 clear toggle one", state_q, '0);
    test_mode = 1'b0; tick();
    chk("R2 clear toggle two", state_q, '0);
    tick();
    chk("R4 capture resumes", state_q, 8'h11);

    // R9: reset with test_mode held high, then shift right away
    rst_n = 1'b0; test_mode = 1'b1; tick();
    chk("R1 state after second reset", state_q, '0);
    rst_n = 1'b1; scan_enable = 1'b1;
    for (int i = 0; i < W; i++) begin
      scan_in = 8'hB6 >> i;
      tick();
    end
    chk("R9 no clear after reset", state_q, 8'hB6);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule